// File: doc/BRIEF.md
# Glitch-safe PLL factor update sequencer

This block moves a PLL configuration register from its present factor set to a requested one without letting the PLL output clock overshoot. The PLL runs a reference through a pre-divider P, a VCO scaled by multipliers N and K, and a post-divider M. A divider change takes effect at once, but a multiplier change makes the VCO slew to its new frequency over time. The sequencer therefore orders its register writes. Any divider that has to grow is written first, and each such write is followed by a long settle interval. N and K are then written together, and the block polls the lock flag. Dividers that have to shrink are written only after lock is seen.

A request carries P, M, N and K codes plus a target code for a dependent bus-clock divider, and a one-cycle start strobe launches it. The block first reads the live register value. It builds every write from that snapshot and changes only the field being updated. A growing bus divider is applied before the first PLL write, and a shrinking one after the last. The lock poll is bounded by a programmable limit. When the limit runs out, the sequence is abandoned and an error is flagged.

Top module: `pll_retune_seq`

## Requirements
- R1: After a sequence that sees lock, the P, M, N and K fields of the written register equal the request. Every bit outside those fields keeps its value from the snapshot, except the lock bit at LOCK_POS, which is always written as 0.
- R2: When the requested P exceeds the current P, the first PLL write changes only the P field. No further write follows within DIV_SETTLE cycles of it.
- R3: When the requested M exceeds the current M, a write changing only the M field follows any rising P write and comes before the N/K write. No further write follows within DIV_SETTLE cycles of it.
- R4: N and K are written together in a single write. No write follows for at least MUL_SETTLE cycles. The block then polls cfg_rd[LOCK_POS] and issues no write until that bit reads 1.
- R5: A requested P or M smaller than the current value is written only after lock. P is written first and M second, each as a write of its own.
- R6: A factor that does not move gets no write and no settle wait. The number of writes equals the count of rising P, rising M, changed N/K, falling P and falling M.
- R7: A larger bus divider code is applied before the first PLL write, and a smaller one only after the last. While any PLL write occurs, bus_div holds the larger of the old and new codes.
- R8: With a PLL that slews its VCO and reports lock only once it has settled, the output frequency at every cycle stays at or below the larger of the start and end frequencies.
- R9: A start pulse that arrives while busy is high is ignored, and the running sequence completes its own request.
- R10: busy rises in the cycle after start and stays high for the whole sequence. done is a single-cycle pulse in the first cycle after busy falls.
- R11: If lock is not seen within lock_limit+1 poll cycles, lock_err is set together with done and the falling P/M writes and the bus decrease are skipped. lock_err holds until the next accepted start clears it.
- R12: After reset, busy, done, cfg_wr_en and lock_err are 0 and bus_div equals BUS_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| req_p | input | P_W | Requested pre-divider code |
| req_m | input | M_W | Requested post-divider code |
| req_n | input | N_W | Requested N multiplier code |
| req_k | input | K_W | Requested K multiplier code |
| req_bus | input | BUS_W | Requested bus-clock divider code |
| lock_limit | input | TO_W | Lock poll budget in cycles, minus one |
| cfg_rd | input | REG_W | Live PLL register value, including the lock flag |
| cfg_wr_en | output | 1 | PLL register write strobe |
| cfg_wr_data | output | REG_W | PLL register write value |
| bus_div | output | BUS_W | Dependent bus-clock divider code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| lock_err | output | 1 | Lock poll ran out of budget |

## Verification
The bench builds a 16-bit register with two-bit P, M and K fields and a three-bit N field. It sets DIV_SETTLE to 16 and MUL_SETTLE to 4. These settings keep each sequence within about a hundred cycles, so a couple of hundred factor transitions can be swept, covering every combination of rising, falling and unchanged dividers and multipliers. The PLL model in the bench slews its VCO one step per cycle and adds a random lock delay, which lets the bench recompute the output frequency every cycle against the start and end values. A forced never-lock case exercises the timeout path.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int REG_W      = 32,
  parameter int P_LSB      = 16,
  parameter int P_W        = 2,
  parameter int M_LSB      = 0,
  parameter int M_W        = 2,
  parameter int N_LSB      = 8,
  parameter int N_W        = 5,
  parameter int K_LSB      = 4,
  parameter int K_W        = 2,
  parameter int LOCK_POS   = 28,
  parameter int BUS_W      = 2,
  parameter int BUS_RST    = 0,
  parameter int DIV_SETTLE = 2000,
  parameter int MUL_SETTLE = 20,
  parameter int TO_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [P_W-1:0]   req_p,
  input  logic [M_W-1:0]   req_m,
  input  logic [N_W-1:0]   req_n,
  input  logic [K_W-1:0]   req_k,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [TO_W-1:0]  lock_limit,
  input  logic [REG_W-1:0] cfg_rd,
  output logic             cfg_wr_en,
  output logic [REG_W-1:0] cfg_wr_data,
  output logic [BUS_W-1:0] bus_div,
  output logic             busy,
  output logic             done,
  output logic             lock_err
);
  localparam int LONGEST = (DIV_SETTLE > MUL_SETTLE) ? DIV_SETTLE : MUL_SETTLE;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_BUS_UP, S_P_UP, S_P_WT, S_M_UP, S_M_WT,
    S_NK, S_NK_WT, S_POLL, S_P_DN, S_M_DN, S_BUS_DN
  } st_t;

  st_t              st;
  logic [REG_W-1:0] shadow;
  logic [P_W-1:0]   rp;
  logic [M_W-1:0]   rm;
  logic [N_W-1:0]   rn;
  logic [K_W-1:0]   rk;
  logic [BUS_W-1:0] rbus;
  logic [CNT_W-1:0] cnt;
  logic [TO_W-1:0]  tocnt;
  logic             wr_q;

  wire [P_W-1:0] cur_p    = shadow[P_LSB +: P_W];
  wire [M_W-1:0] cur_m    = shadow[M_LSB +: M_W];
  wire [N_W-1:0] cur_n    = shadow[N_LSB +: N_W];
  wire [K_W-1:0] cur_k    = shadow[K_LSB +: K_W];
  wire           lock_now = cfg_rd[LOCK_POS];

  assign busy        = (st != S_IDLE);
  assign cfg_wr_en   = wr_q;
  assign cfg_wr_data = shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      shadow   <= '0;
      rp       <= '0;
      rm       <= '0;
      rn       <= '0;
      rk       <= '0;
      rbus     <= '0;
      cnt      <= '0;
      tocnt    <= '0;
      wr_q     <= 1'b0;
      done     <= 1'b0;
      lock_err <= 1'b0;
      bus_div  <= BUS_W'(BUS_RST);
    end else begin
      wr_q <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          shadow           <= cfg_rd;
          shadow[LOCK_POS] <= 1'b0;
          rp       <= req_p;
          rm       <= req_m;
          rn       <= req_n;
          rk       <= req_k;
          rbus     <= req_bus;
          lock_err <= 1'b0;
          st       <= S_BUS_UP;
        end
        S_BUS_UP: begin
          if (rbus > bus_div) bus_div <= rbus;
          st <= S_P_UP;
        end
        S_P_UP: if (rp > cur_p) begin
          shadow[P_LSB +: P_W] <= rp;
          wr_q <= 1'b1;
          cnt  <= CNT_W'(DIV_SETTLE - 1);
          st   <= S_P_WT;
        end else st <= S_M_UP;
        S_P_WT: if (cnt == '0) st <= S_M_UP; else cnt <= cnt - 1'b1;
        S_M_UP: if (rm > cur_m) begin
          shadow[M_LSB +: M_W] <= rm;
          wr_q <= 1'b1;
          cnt  <= CNT_W'(DIV_SETTLE - 1);
          st   <= S_M_WT;
        end else st <= S_NK;
        S_M_WT: if (cnt == '0) st <= S_NK; else cnt <= cnt - 1'b1;
        S_NK: if (rn != cur_n || rk != cur_k) begin
          shadow[N_LSB +: N_W] <= rn;
          shadow[K_LSB +: K_W] <= rk;
          wr_q <= 1'b1;
          cnt  <= CNT_W'(MUL_SETTLE - 1);
          st   <= S_NK_WT;
        end else st <= S_P_DN;
        S_NK_WT: if (cnt == '0) begin
          tocnt <= '0;
          st    <= S_POLL;
        end else cnt <= cnt - 1'b1;
        S_POLL: if (lock_now) st <= S_P_DN;
        else if (tocnt == lock_limit) begin
          lock_err <= 1'b1;
          done     <= 1'b1;
          st       <= S_IDLE;
        end else tocnt <= tocnt + 1'b1;
        S_P_DN: begin
          if (rp < cur_p) begin
            shadow[P_LSB +: P_W] <= rp;
            wr_q <= 1'b1;
          end
          st <= S_M_DN;
        end
        S_M_DN: begin
          if (rm < cur_m) begin
            shadow[M_LSB +: M_W] <= rm;
            wr_q <= 1'b1;
          end
          st <= S_BUS_DN;
        end
        S_BUS_DN: begin
          if (rbus < bus_div) bus_div <= rbus;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(rp) && $stable(rm) && $stable(rn) && $stable(rk) && $stable(rbus)));

  // R4
  poll_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> !cfg_wr_en);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  bus_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(bus_div));
endmodule

// File: tb/tb_pll_retune_seq.sv
module tb_pll_retune_seq;
  localparam int DS = 16;
  localparam int MS = 4;
  localparam logic [15:0] PM = 16'h3000, MM = 16'h0003, NM = 16'h0070, KM = 16'h0300;
  localparam logic [15:0] INIT = 16'h19B1;
  localparam logic [15:0] SPARE = ~(PM | MM | NM | KM | 16'h8000);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] req_p = '0, req_m = '0, req_k = '0, req_bus = '0;
  logic [2:0] req_n = '0;
  logic [9:0] lock_limit = 10'd1000;
  logic [15:0] cfg_rd, cfg_wr_data;
  logic cfg_wr_en, busy, done, lock_err;
  logic [1:0] bus_div;

  always #10 clk = ~clk;

  pll_retune_seq #(.REG_W(16), .P_LSB(12), .P_W(2), .M_LSB(0), .M_W(2), .N_LSB(4), .N_W(3),
    .K_LSB(8), .K_W(2), .LOCK_POS(15), .BUS_W(2), .BUS_RST(1), .DIV_SETTLE(DS),
    .MUL_SETTLE(MS), .TO_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_p(req_p), .req_m(req_m), .req_n(req_n),
    .req_k(req_k), .req_bus(req_bus), .lock_limit(lock_limit), .cfg_rd(cfg_rd),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .bus_div(bus_div), .busy(busy),
    .done(done), .lock_err(lock_err));

  function automatic int nk_of(logic [15:0] r);
    return (int'(r[6:4]) + 1) * (int'(r[9:8]) + 1);
  endfunction
  function automatic int dv_of(logic [15:0] r);
    return (int'(r[13:12]) + 1) * (int'(r[1:0]) + 1);
  endfunction

  logic [15:0] pll_reg = INIT;
  logic lock_q = 1'b1, never_lock = 1'b0;
  int vco = 0, dly = 0, cyc = 0;
  assign cfg_rd = {lock_q, pll_reg[14:0]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      pll_reg <= INIT; vco <= nk_of(INIT); lock_q <= 1'b1; dly <= 0;
    end else begin
      if (vco < nk_of(pll_reg)) vco <= vco + 1;
      else if (vco > nk_of(pll_reg)) vco <= vco - 1;
      if (cfg_wr_en) begin
        pll_reg <= cfg_wr_data & 16'h7fff;
        if (((cfg_wr_data ^ pll_reg) & (NM | KM)) != 0) begin
          lock_q <= 1'b0; dly <= int'($urandom_range(12, 0));
        end
      end else if (!lock_q && !never_lock && vco == nk_of(pll_reg)) begin
        if (dly == 0) lock_q <= 1'b1; else dly <= dly - 1;
      end
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // monitor state for one transition
  bit in_txn = 0, ovs_bad, order_bad, gap_bad, field_bad, bus_bad, nk_seen, fall_seen, mup_seen;
  int nwr, last_kind, last_cyc;
  real fmax;
  logic [1:0] bus_hi;

  always @(negedge clk) if (in_txn) begin
    real fo;
    fo = real'(vco) / real'(dv_of(pll_reg));
    if (fo > fmax + 1e-9) ovs_bad = 1;
    if (cfg_wr_en) begin
      logic [15:0] prev, d;
      prev = pll_reg & 16'h7fff;
      d = cfg_wr_data ^ prev;
      if (bus_div != bus_hi) bus_bad = 1;
      if (last_kind == 1 && cyc - last_cyc < DS) gap_bad = 1;
      if (last_kind == 2 && cyc - last_cyc < MS) gap_bad = 1;
      last_cyc = cyc;
      nwr++;
      if (d != 0 && (d & ~PM) == 0) begin
        if (cfg_wr_data[13:12] > prev[13:12]) begin
          if (nk_seen || fall_seen || mup_seen) order_bad = 1;
          last_kind = 1;
        end else begin
          if (!lock_q || fall_seen) order_bad = 1;
          fall_seen = 1; last_kind = 3;
        end
      end else if (d != 0 && (d & ~MM) == 0) begin
        if (cfg_wr_data[1:0] > prev[1:0]) begin
          if (nk_seen || fall_seen) order_bad = 1;
          mup_seen = 1; last_kind = 1;
        end else begin
          if (!lock_q) order_bad = 1;
          fall_seen = 1; last_kind = 3;
        end
      end else if (d != 0 && (d & ~(NM | KM)) == 0) begin
        if (nk_seen || fall_seen) order_bad = 1;
        nk_seen = 1; last_kind = 2;
      end else field_bad = 1;
    end
  end

  task automatic run_txn(logic [1:0] p, logic [1:0] m, logic [2:0] n, logic [1:0] k,
                         logic [1:0] b, bit exp_err, bit poke);
    logic [15:0] o;
    int expw, w;
    logic [1:0] ep, em, eb;
    o = pll_reg;
    fmax = real'(vco) / real'(dv_of(o));
    begin
      real f1;
      f1 = real'((int'(n) + 1) * (int'(k) + 1)) / real'((int'(p) + 1) * (int'(m) + 1));
      if (f1 > fmax) fmax = f1;
    end
    bus_hi = (b > bus_div) ? b : bus_div;
    expw = int'(p > o[13:12]) + int'(m > o[1:0]) + int'(n != o[6:4] || k != o[9:8]);
    if (!exp_err) expw += int'(p < o[13:12]) + int'(m < o[1:0]);
    ep = exp_err ? ((p > o[13:12]) ? p : o[13:12]) : p;
    em = exp_err ? ((m > o[1:0]) ? m : o[1:0]) : m;
    eb = exp_err ? bus_hi : b;
    ovs_bad = 0; order_bad = 0; gap_bad = 0; field_bad = 0; bus_bad = 0;
    nk_seen = 0; fall_seen = 0; mup_seen = 0; nwr = 0; last_kind = 0; last_cyc = 0;
    @(negedge clk);
    req_p = p; req_m = m; req_n = n; req_k = k; req_bus = b; start = 1'b1; in_txn = 1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    if (poke) begin
      @(negedge clk); @(negedge clk);
      req_p = ~p; req_m = ~m; req_n = ~n; req_k = ~k; req_bus = ~b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; if (!done) chk(busy, "R10 busy held", int'(busy), 1); end
    chk(done && !busy, "R10 done at end", int'(done), 1);
    @(negedge clk);
    chk(!done && !busy, "R10 done one cycle", int'(done), 0);
    in_txn = 0;
    chk(pll_reg[13:12] == ep && pll_reg[1:0] == em, "R1 P/M fields", int'({pll_reg[13:12], pll_reg[1:0]}), int'({ep, em}));
    chk(pll_reg[6:4] == n && pll_reg[9:8] == k, "R1 N/K fields", int'({pll_reg[6:4], pll_reg[9:8]}), int'({n, k}));
    chk((pll_reg & SPARE) == (INIT & SPARE), "R1 other bits kept", int'(pll_reg & SPARE), int'(INIT & SPARE));
    chk(!field_bad, "R4 single-group writes", int'(field_bad), 0);
    chk(nwr == expw, "R6 write count", nwr, expw);
    chk(!order_bad, "R5 R2 R3 write order", int'(order_bad), 0);
    chk(!gap_bad, "R2 R3 R4 settle gaps", int'(gap_bad), 0);
    chk(!ovs_bad, "R8 no overshoot", int'(ovs_bad), 0);
    chk(!bus_bad, "R7 bus divider during writes", int'(bus_bad), 0);
    chk(bus_div == eb, "R7 final bus divider", int'(bus_div), int'(eb));
    chk(lock_err == exp_err, "R11 lock error flag", int'(lock_err), int'(exp_err));
  endtask

  bit wd_hit = 0;
  always @(posedge clk) if (cyc > 150000 && !wd_hit) begin
    wd_hit = 1;
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    chk(!busy && !done && !cfg_wr_en && !lock_err, "R12 reset outputs",
        int'({busy, done, cfg_wr_en, lock_err}), 0);
    chk(bus_div == 2'd1, "R12 reset bus divider", int'(bus_div), 1);
    // R6: unchanged request gives no writes
    run_txn(2'd1, 2'd1, 3'd3, 2'd1, 2'd1, 0, 0);
    // R2 R3 R5: all dividers up, then all down
    run_txn(2'd3, 2'd3, 3'd7, 2'd3, 2'd3, 0, 0);
    run_txn(2'd0, 2'd0, 3'd0, 2'd0, 2'd0, 0, 0);
    // R9: second start while busy is ignored
    run_txn(2'd2, 2'd3, 3'd5, 2'd1, 2'd2, 0, 1);
    // sweep of transitions
    for (int i = 0; i < 200; i++) begin
      int j;
      j = (i * 73 + 29) % 256;
      run_txn(j[1:0], j[3:2], j[6:4], {j[7], i[0]}, 2'(i ^ j), 0, 0);
    end
    // R11: lock never comes
    never_lock = 1'b1;
    lock_limit = 10'd40;
    run_txn(2'd0, 2'd3, (pll_reg[6:4] == 3'd6) ? 3'd2 : 3'd6, 2'd2, 2'd0, 1, 0);
    repeat (5) @(negedge clk);
    chk(lock_err == 1'b1, "R11 error held", int'(lock_err), 1);
    never_lock = 1'b0;
    lock_limit = 10'd1000;
    repeat (30) @(negedge clk);
    run_txn(2'd1, 2'd0, 3'd4, 2'd3, 2'd1, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule